// File: doc/BRIEF.md
# Test Access Port Controller

This block is the serial test port of a chip. A single mode-select line steps a sixteen-state controller on each rising edge of the test clock. A four-bit instruction register and a one-bit bypass register sit between the serial data input and the serial data output. The loaded instruction is decoded into control lines for an external boundary register and for the chip core. These lines are shift, capture/shift clock enable, update strobe, the boundary mode, a request to float all chip outputs, and a start request for an on-chip self-test engine.

On a board, several such ports share the clock, mode-select and reset lines, while their serial data lines are chained. A tester first shifts an instruction into every chip. It then moves data through the register that each instruction selects, either the boundary register (whose serial output comes back on `bsr_so`) or the bypass bit. While the controller sits in its reset state, the chip runs normally and no test control is active.

Top module: `tap_port`

## Requirements
- R1: From any controller state, five consecutive rising clock edges with `tms` = 1 bring the controller to its reset state, and the instruction becomes BYPASS (`mode`, `hiz_req`, `selftest_go` low).
- R2: Driving `trst_n` low forces the reset state at once, without a clock edge, with BYPASS loaded and `mode`, `hiz_req`, `selftest_go`, `tdo_oe` and the three strobes low.
- R3: In Capture-IR the instruction shift register loads 0001. During Shift-IR it shifts `tdi` in at the most significant end and presents its least significant bit on `tdo`, so the captured bits appear as 1,0,0,0.
- R4: BYPASS (code 1111) routes the one-bit bypass register to `tdo`. The bit loads 0 in Capture-DR and takes `tdi` on each Shift-DR edge, so the output during a data scan is 0 followed by the input delayed by one bit.
- R5: When the boundary register is selected, `clock_dr` is high in Capture-DR with `shift_dr` low, `clock_dr` and `shift_dr` are both high in Shift-DR, and `update_dr` is high only in Update-DR. When the bypass bit is selected, all three stay low.
- R6: EXTEST (0000) and INTEST (0011) select the boundary register with `mode` high. SAMPLE (0010) selects it with `mode` low. In all three cases `tdo` in Shift-DR carries `bsr_so`.
- R7: HIGHZ (0101) raises `hiz_req` with `mode` low. CLAMP (0100) raises `mode` with `hiz_req` low. Both route the bypass bit to `tdo`.
- R8: With SELFTEST (0110) loaded, `selftest_go` is high exactly while the controller is in Run-Test/Idle. The data scan path is the bypass bit.
- R9: Any code not listed in R4 to R8 decodes as BYPASS, for example 1010 and the capture pattern 0001.
- R10: `tdo` and `tdo_oe` change only on the falling clock edge. `tdo_oe` is high only for cycles spent in Shift-DR or Shift-IR.
- R11: A newly shifted instruction takes effect only on the rising edge that leaves Update-IR. Until then the decoded outputs keep the previous instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low port reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| bsr_so | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| shift_dr | output | 1 | Boundary register shift select |
| clock_dr | output | 1 | Boundary register capture/shift clock enable |
| update_dr | output | 1 | Boundary register update strobe |
| mode | output | 1 | Boundary cells drive the pins/core |
| hiz_req | output | 1 | Request to float all chip outputs |
| selftest_go | output | 1 | Self-test start request |

## Verification
A wrong controller state shows up within one clock as a strobe in the wrong cycle or an output enable asserted outside a shift, and the bench checks every strobe in every scan cycle. A corrupted instruction register shows as a wrong decode (`mode`, `hiz_req`, `selftest_go`) right after Update-IR, or as a wrong capture bit in the first four `tdo` bits of the next instruction scan. A bypass or routing fault shows as a `tdo` stream that differs from `tdi` delayed by one bit, or from `bsr_so`, on the first falling edge of Shift-DR.

// File: rtl/tap_pkg.sv
`timescale 1ns/1ps
package tap_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR    = 4'd0,
    ST_RTI    = 4'd1,
    ST_SEL_DR = 4'd2,
    ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,
    ST_EX1_DR = 4'd5,
    ST_PAU_DR = 4'd6,
    ST_EX2_DR = 4'd7,
    ST_UPD_DR = 4'd8,
    ST_SEL_IR = 4'd9,
    ST_CAP_IR = 4'd10,
    ST_SH_IR  = 4'd11,
    ST_EX1_IR = 4'd12,
    ST_PAU_IR = 4'd13,
    ST_EX2_IR = 4'd14,
    ST_UPD_IR = 4'd15
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST   = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 4'b0010;
  localparam logic [IR_W-1:0] OP_INTEST   = 4'b0011;
  localparam logic [IR_W-1:0] OP_CLAMP    = 4'b0100;
  localparam logic [IR_W-1:0] OP_HIGHZ    = 4'b0101;
  localparam logic [IR_W-1:0] OP_SELFTEST = 4'b0110;
  localparam logic [IR_W-1:0] OP_BYPASS   = 4'b1111;

  typedef struct packed {
    logic sel_bsr;  // boundary register on the scan path
    logic mode;     // boundary cells drive
    logic hiz;      // float all outputs
    logic bist;     // self-test instruction
  } tap_dec_t;

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e st_q,
  output tap_state_e st_d
);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_TLR:    st_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    st_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: st_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: st_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  st_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: st_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: st_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: st_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: st_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: st_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: st_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  st_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: st_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: st_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: st_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: st_d = tms ? ST_SEL_DR : ST_RTI;
      default:   st_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) st_q <= ST_TLR;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
  import tap_pkg::*;
#(
  parameter logic [IR_W-1:0] CAP_PATTERN = 4'b0001
) (
  input  logic            tck,
  input  logic            rst_n,
  input  tap_state_e      st_q,
  input  tap_state_e      st_d,
  input  logic            tdi,
  output logic            ir_so,
  output logic [IR_W-1:0] instr
);

  logic [IR_W-1:0] sr_q, sr_d;
  logic            sr_en;
  logic [IR_W-1:0] hold_d;
  logic            hold_en;

  // shift stage: capture fixed pattern, shift LSB first
  always_comb begin
    sr_en = 1'b0;
    sr_d  = sr_q;
    if (st_q == ST_CAP_IR) begin
      sr_en = 1'b1;
      sr_d  = CAP_PATTERN;
    end else if (st_q == ST_SH_IR) begin
      sr_en = 1'b1;
      sr_d  = {tdi, sr_q[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)     sr_q <= CAP_PATTERN;
    else if (sr_en) sr_q <= sr_d;
  end

  // holding stage: loads on leaving Update-IR, resets on entering reset state
  always_comb begin
    hold_en = 1'b0;
    hold_d  = instr;
    if (st_d == ST_TLR) begin
      hold_en = 1'b1;
      hold_d  = OP_BYPASS;
    end else if (st_q == ST_UPD_IR) begin
      hold_en = 1'b1;
      hold_d  = sr_q;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)       instr <= OP_BYPASS;
    else if (hold_en) instr <= hold_d;
  end

  assign ir_so = sr_q[0];

endmodule

// File: rtl/tap_decode.sv
`timescale 1ns/1ps
module tap_decode
  import tap_pkg::*;
(
  input  logic [IR_W-1:0] instr,
  output tap_dec_t        dec
);

  always_comb begin
    dec = '0;
    unique case (instr)
      OP_EXTEST:   begin dec.sel_bsr = 1'b1; dec.mode = 1'b1; end
      OP_INTEST:   begin dec.sel_bsr = 1'b1; dec.mode = 1'b1; end
      OP_SAMPLE:   begin dec.sel_bsr = 1'b1; end
      OP_CLAMP:    begin dec.mode    = 1'b1; end
      OP_HIGHZ:    begin dec.hiz     = 1'b1; end
      OP_SELFTEST: begin dec.bist    = 1'b1; end
      default:     dec = '0;   // BYPASS and every unused code
    endcase
  end

endmodule

// File: rtl/tap_port.sv
`timescale 1ns/1ps
module tap_port
  import tap_pkg::*;
#(
  parameter int              RST_STAGES  = 2,
  parameter logic [IR_W-1:0] CAP_PATTERN = 4'b0001
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_so,
  output logic tdo,
  output logic tdo_oe,
  output logic shift_dr,
  output logic clock_dr,
  output logic update_dr,
  output logic mode,
  output logic hiz_req,
  output logic selftest_go
);

  // reset: asserted asynchronously, released on tck
  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_n_q;

  genvar g;
  generate
    for (g = 0; g < RST_STAGES; g++) begin : g_rst
      always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) rst_sync_q[g] <= 1'b0;
        else         rst_sync_q[g] <= (g == 0) ? 1'b1 : rst_sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rst_n_q = rst_sync_q[RST_STAGES-1] & trst_n;

  tap_state_e      st_q, st_d;
  logic            ir_so;
  logic [IR_W-1:0] instr;
  tap_dec_t        dec;

  tap_fsm i_fsm (
    .tck   (tck),
    .rst_n (rst_n_q),
    .tms   (tms),
    .st_q  (st_q),
    .st_d  (st_d)
  );

  tap_ir #(.CAP_PATTERN(CAP_PATTERN)) i_ir (
    .tck   (tck),
    .rst_n (rst_n_q),
    .st_q  (st_q),
    .st_d  (st_d),
    .tdi   (tdi),
    .ir_so (ir_so),
    .instr (instr)
  );

  tap_decode i_dec (
    .instr (instr),
    .dec   (dec)
  );

  // bypass bit
  logic byp_q, byp_d, byp_en;
  always_comb begin
    byp_en = 1'b0;
    byp_d  = byp_q;
    if (st_q == ST_CAP_DR) begin
      byp_en = 1'b1;
      byp_d  = 1'b0;
    end else if (st_q == ST_SH_DR) begin
      byp_en = 1'b1;
      byp_d  = tdi;
    end
  end

  always_ff @(posedge tck or negedge rst_n_q) begin
    if (!rst_n_q)    byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  // serial output, retimed on the falling edge
  logic in_shift, tdo_d;
  always_comb begin
    in_shift = (st_q == ST_SH_IR) || (st_q == ST_SH_DR);
    if (st_q == ST_SH_IR)      tdo_d = ir_so;
    else if (!in_shift)        tdo_d = 1'b0;
    else if (dec.sel_bsr)      tdo_d = bsr_so;
    else                       tdo_d = byp_q;
  end

  always_ff @(negedge tck or negedge rst_n_q) begin
    if (!rst_n_q) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= in_shift;
    end
  end

  // boundary and chip controls
  assign shift_dr    = dec.sel_bsr && (st_q == ST_SH_DR);
  assign clock_dr    = dec.sel_bsr && ((st_q == ST_CAP_DR) || (st_q == ST_SH_DR));
  assign update_dr   = dec.sel_bsr && (st_q == ST_UPD_DR);
  assign mode        = dec.mode;
  assign hiz_req     = dec.hiz;
  assign selftest_go = dec.bist && (st_q == ST_RTI);

endmodule

// File: rtl/tap_port_chk.sv
`timescale 1ns/1ps
module tap_port_chk
  import tap_pkg::*;
(
  input logic       tck,
  input logic       rst_n,
  input tap_state_e st,
  input logic       tms,
  input logic       mode,
  input logic       hiz_req,
  input logic       selftest_go,
  input logic       tdo_oe,
  input logic       shift_dr,
  input logic       clock_dr,
  input logic       update_dr
);

  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)            ones_q <= 3'd0;
    else if (!tms)         ones_q <= 3'd0;
    else if (ones_q < 3'd5) ones_q <= ones_q + 3'd1;
  end

  p_five_ones_r1: assert property (@(posedge tck) disable iff (!rst_n)
    (ones_q >= 3'd5) |-> (st == ST_TLR));

  p_reset_quiet_r2: assert property (@(posedge tck) disable iff (!rst_n)
    (st == ST_TLR) |-> (!mode && !hiz_req && !selftest_go));

  p_shift_has_clk_r5: assert property (@(posedge tck) disable iff (!rst_n)
    shift_dr |-> clock_dr);

  p_update_after_exit_r5: assert property (@(posedge tck) disable iff (!rst_n)
    $rose(update_dr) |-> ($past(st) == ST_EX1_DR || $past(st) == ST_EX2_DR));

  p_strobe_excl_r5: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({update_dr, clock_dr}));

  p_hiz_no_mode_r7: assert property (@(posedge tck) disable iff (!rst_n)
    hiz_req |-> !mode);

  p_selftest_idle_r8: assert property (@(posedge tck) disable iff (!rst_n)
    selftest_go |-> (st == ST_RTI));

  p_oe_shift_r10: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> (st == ST_SH_DR || st == ST_SH_IR));

  p_instr_hold_r11: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(st) != ST_UPD_IR && st != ST_TLR) |-> ($stable(mode) && $stable(hiz_req)));

endmodule

bind tap_port tap_port_chk i_chk (
  .tck         (tck),
  .rst_n       (rst_n_q),
  .st          (st_q),
  .tms         (tms),
  .mode        (mode),
  .hiz_req     (hiz_req),
  .selftest_go (selftest_go),
  .tdo_oe      (tdo_oe),
  .shift_dr    (shift_dr),
  .clock_dr    (clock_dr),
  .update_dr   (update_dr)
);

// File: tb/test_tap_port.sv
`timescale 1ns/1ps
module test_tap_port;

  logic tck = 1'b0;
  logic trst_n, tms, tdi, bsr_so;
  logic tdo, tdo_oe, shift_dr, clock_dr, update_dr, mode, hiz_req, selftest_go;

  always #2 tck = ~tck;   // 250 MHz

  tap_port i_tap_port (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .shift_dr(shift_dr), .clock_dr(clock_dr),
    .update_dr(update_dr), .mode(mode), .hiz_req(hiz_req), .selftest_go(selftest_go)
  );

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic  bit_v;
    string tag;
  } exp_t;
  exp_t expq[$];

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input logic b, input string tag);
    expq.push_back('{b, tag});
  endtask

  // monitor: compare each enabled tdo bit after the falling edge
  always @(negedge tck) begin
    #1;
    if (tdo_oe === 1'b1) begin
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL R10 unexpected tdo_oe act=1 exp=0 at %0t", $time);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (tdo !== e.bit_v) begin
          bad++;
          $display("FAIL %s tdo act=%0b exp=%0b at %0t", e.tag, tdo, e.bit_v, $time);
        end
      end
    end
  end

  // one rising edge; inputs change 1 ns after the edge
  task automatic clk(input logic t, input logic d);
    tms = t;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  task automatic check_dec(input string tag, input logic m, input logic h, input logic g);
    chk({tag, " mode"}, mode, m);
    chk({tag, " hiz_req"}, hiz_req, h);
    chk({tag, " selftest_go"}, selftest_go, g);
  endtask

  // from Run-Test/Idle: scan an instruction, return to Run-Test/Idle
  task automatic load_ir(input logic [3:0] code, input bit use_pause, input bit stop_exit);
    clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0);   // now in Shift-IR
    for (int i = 0; i < 4; i++) begin
      push((i == 0) ? 1'b1 : 1'b0, "R3");
      clk(i == 3, code[i]);
    end
    if (stop_exit) return;                       // left in Exit1-IR
    if (use_pause) begin clk(0, 0); clk(0, 0); clk(1, 0); end
    clk(1, 0);                                    // Update-IR
    clk(0, 0);                                    // Run-Test/Idle
  endtask

  // from Run-Test/Idle: scan n data bits, return to Run-Test/Idle
  task automatic scan_dr(input int n, input logic bsel, input logic [15:0] data,
                         input logic [15:0] bpat, input string tag);
    logic prev;
    clk(1, 0); clk(0, 0);                         // Capture-DR
    chk("R5 capture clock_dr", clock_dr, bsel);
    chk("R5 capture shift_dr", shift_dr, 1'b0);
    clk(0, 0);                                    // Shift-DR
    chk("R10 oe before falling edge", tdo_oe, 1'b0);
    prev = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk("R5 shift shift_dr", shift_dr, bsel);
      chk("R5 shift clock_dr", clock_dr, bsel);
      bsr_so = bpat[i];
      push(bsel ? bpat[i] : prev, tag);
      prev = data[i];
      clk(i == n - 1, data[i]);
    end
    chk("R10 oe held until falling edge", tdo_oe, 1'b1);
    chk("R5 exit clock_dr", clock_dr, 1'b0);
    clk(1, 0);                                    // Update-DR
    chk("R5 update_dr", update_dr, bsel);
    clk(0, 0);                                    // Run-Test/Idle
    chk("R5 idle update_dr", update_dr, 1'b0);
    chk("R10 idle oe", tdo_oe, 1'b0);
  endtask

  task automatic summary;
    if (expq.size() != 0) begin
      total++; bad++;
      $display("FAIL R10 missing tdo bits act=%0d exp=0", expq.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge tck);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    trst_n = 1'b0; tms = 1'b1; tdi = 1'b0; bsr_so = 1'b0;
    repeat (3) @(posedge tck);
    #1;
    // R2 reset state
    check_dec("R2 reset", 1'b0, 1'b0, 1'b0);
    chk("R2 reset oe", tdo_oe, 1'b0);
    chk("R2 reset clock_dr", clock_dr, 1'b0);
    chk("R2 reset update_dr", update_dr, 1'b0);
    trst_n = 1'b1;
    clk(1, 0); clk(1, 0); clk(1, 0); clk(0, 0);   // Run-Test/Idle

    // R3, R6: EXTEST through the pause path
    load_ir(4'b0000, 1, 0);
    check_dec("R6 extest", 1'b1, 1'b0, 1'b0);
    scan_dr(6, 1'b1, 16'h0015, 16'h002D, "R6");

    // R11: new code shifted but not updated
    load_ir(4'b0010, 0, 1);
    chk("R11 mode before update", mode, 1'b1);
    clk(1, 0);
    chk("R11 mode in update state", mode, 1'b1);
    clk(0, 0);
    check_dec("R11 sample after update", 1'b0, 1'b0, 1'b0);
    scan_dr(5, 1'b1, 16'h000A, 16'h0013, "R6");

    // R6 INTEST
    load_ir(4'b0011, 0, 0);
    check_dec("R6 intest", 1'b1, 1'b0, 1'b0);
    scan_dr(4, 1'b1, 16'h0006, 16'h0009, "R6");

    // R7 HIGHZ and CLAMP
    load_ir(4'b0101, 0, 0);
    check_dec("R7 highz", 1'b0, 1'b1, 1'b0);
    scan_dr(5, 1'b0, 16'h001B, 16'h001F, "R7");
    load_ir(4'b0100, 0, 0);
    check_dec("R7 clamp", 1'b1, 1'b0, 1'b0);
    scan_dr(5, 1'b0, 16'h0016, 16'h001F, "R7");

    // R8 SELFTEST
    load_ir(4'b0110, 0, 0);
    check_dec("R8 selftest idle", 1'b0, 1'b0, 1'b1);
    clk(1, 0);
    chk("R8 selftest off in select", selftest_go, 1'b0);
    clk(0, 0); clk(1, 0); clk(1, 0); clk(0, 0);   // Cap, Exit1, Update, Idle
    chk("R8 selftest back in idle", selftest_go, 1'b1);
    scan_dr(3, 1'b0, 16'h0005, 16'h0007, "R8");

    // R9 unused codes
    load_ir(4'b1010, 0, 0);
    check_dec("R9 code 1010", 1'b0, 1'b0, 1'b0);
    scan_dr(4, 1'b0, 16'h000D, 16'h000F, "R9");
    load_ir(4'b0001, 0, 0);
    check_dec("R9 code 0001", 1'b0, 1'b0, 1'b0);
    scan_dr(3, 1'b0, 16'h0003, 16'h0007, "R9");

    // R4 BYPASS
    load_ir(4'b1111, 0, 0);
    check_dec("R4 bypass", 1'b0, 1'b0, 1'b0);
    scan_dr(8, 1'b0, 16'h00B5, 16'h00FF, "R4");

    // R1 from Shift-DR under EXTEST
    load_ir(4'b0000, 0, 0);
    chk("R1 pre mode", mode, 1'b1);
    clk(1, 0); clk(0, 0); clk(0, 0);              // Shift-DR
    bsr_so = 1'b1;
    push(1'b1, "R1");
    for (int i = 0; i < 5; i++) clk(1, 0);
    check_dec("R1 after five ones", 1'b0, 1'b0, 1'b0);
    chk("R1 oe", tdo_oe, 1'b0);
    clk(0, 0);

    // R1 from Pause-IR
    clk(1, 0); clk(1, 0); clk(0, 0); clk(1, 0); clk(0, 0);   // Pause-IR
    for (int i = 0; i < 5; i++) clk(1, 0);
    check_dec("R1 from pause", 1'b0, 1'b0, 1'b0);
    clk(0, 0);

    // R2 asynchronous reset mid-operation
    load_ir(4'b0011, 0, 0);
    chk("R2 pre mode", mode, 1'b1);
    #0.5;
    trst_n = 1'b0;
    #0.5;
    check_dec("R2 async", 1'b0, 1'b0, 1'b0);
    @(posedge tck); #1;
    trst_n = 1'b1;
    clk(1, 0); clk(1, 0); clk(1, 0); clk(0, 0);
    check_dec("R2 after release", 1'b0, 1'b0, 1'b0);
    scan_dr(3, 1'b0, 16'h0006, 16'h0007, "R2");

    repeat (2) @(posedge tck);
    summary();
    $finish;
  end

endmodule